// File: doc/BRIEF.md
# Cascade-Aware Interrupt Request Controller

This block is an eight-input interrupt request controller core that can take either side of a two-device cascade. Each input line feeds a request register. A mask register gates the requests, and an in-service register records the lines that have been acknowledged and not yet closed. Requests are resolved by fixed priority, with line 0 highest. The block raises one interrupt output. An acknowledge input accepts the chosen line and reports its number.

Software sets the block up through a byte-wide register port. One command word starts a short initialisation sequence that loads a vector base, an optional cascade word and an optional fourth word. After that sequence, data writes load the mask. Each line is sensed on a rising edge or on its level, as a separate trigger-mode register selects. A line marked in the cascade register is always sensed on its level. This means a slave that withdraws its output, for example because its own source was masked, also withdraws the master's request, and no interrupt is delivered for it.

Top module: `pic_core`

## Requirements
- R1: With trigger-mode bit 0 (edge), a rising input sets the request bit. The bit stays set after the input falls, until that line is acknowledged.
- R2: With trigger-mode bit 1 (level), the request bit takes the input's value on every clock. When the input drops, the request is withdrawn.
- R3: A line whose cascade bit is 1 is sensed on its level whatever its trigger-mode bit is. If a slave's output falls, the master's interrupt output falls one clock later.
- R4: An accepted acknowledge sets the chosen line's in-service bit. It clears the request bit of an edge-sensed line and leaves a level-sensed request set. It reports the line number on `ack_line` with `ack_valid` high.
- R5: `int_out` is high when the lowest-numbered unmasked request has a lower number than every in-service line. Line 0 has the highest priority.
- R6: A line whose mask bit is 1 never raises `int_out`, but its request is still recorded. Clearing the mask bit lets the request through.
- R7: A command write (address 0) with bit 4 = 0 and bit 5 = 1 is an end-of-interrupt. It clears only the lowest-numbered set in-service bit.
- R8: A command write with bit 4 = 1 starts initialisation: bit 0 = fourth word wanted, bit 1 = single mode. It clears the mask and cascade registers and the in-service register. The data writes (address 1) that follow load, in order: the vector base; then the cascade register, unless single mode is set; then the fourth word, if it was wanted. After that, data writes load the mask.
- R9: Reset clears the request, in-service, cascade, mask, trigger-mode and vector-base registers and drops `int_out`.
- R10: An acknowledge while `int_out` is low gives `ack_valid` = 0 and `ack_line` = 7 (the highest line number), and changes no in-service bit.
- R11: `ack_cascade` is high exactly when an accepted acknowledge picks a line whose cascade bit is 1. A slave's acknowledge input is driven from it.
- R12: Register access: address 2 writes the trigger-mode register. Read select 0 = request, 1 = in-service, 2 = mask, 3 = cascade, 4 = trigger-mode, 5 = vector base, and any other value reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 command, 1 data, 2 trigger-mode |
| reg_wdata | input | 8 | Write data |
| reg_rsel | input | 3 | Read register select |
| reg_rdata | output | 8 | Read data |
| irq_in | input | LINES | Interrupt request inputs |
| int_out | output | 1 | Interrupt request to processor or master |
| ack_in | input | 1 | Acknowledge strobe |
| ack_valid | output | 1 | Acknowledge accepted |
| ack_line | output | IDX_W | Acknowledged line number |
| ack_cascade | output | 1 | Accepted line is fed by a slave |

## Verification
The priority resolver is driven by a table of input words. Each entry combines a different set of simultaneous lines with masks and trigger modes. This shows whether the lowest-numbered unmasked line wins, whether masked lines are skipped, and whether edge-sensed and level-sensed lines resolve the same way. Directed sequences then compare three things. A short pulse on an edge-sensed line must stay latched, while a dropped level-sensed input must be withdrawn. An acknowledged level-sensed line must stay requested but blocked until end-of-interrupt. A line with a higher number must stay blocked by an in-service line with a lower number, while a line with a lower number must nest. The cascade sequence masks and then unmasks a pending slave line. This shows whether the master follows the slave's level or holds a stale request.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_VEC  = 2'd1,
      ST_CASC = 2'd2,
      ST_W4   = 2'd3
   } init_st_t;

   localparam logic [1:0] ADDR_CMD  = 2'd0;
   localparam logic [1:0] ADDR_DATA = 2'd1;
   localparam logic [1:0] ADDR_TRIG = 2'd2;

   localparam int CMD_INIT_BIT   = 4;
   localparam int CMD_EOI_BIT    = 5;
   localparam int W1_NEED4_BIT   = 0;
   localparam int W1_SINGLE_BIT  = 1;

   localparam logic [2:0] RSEL_REQ  = 3'd0;
   localparam logic [2:0] RSEL_ISR  = 3'd1;
   localparam logic [2:0] RSEL_MASK = 3'd2;
   localparam logic [2:0] RSEL_CASC = 3'd3;
   localparam logic [2:0] RSEL_TRIG = 3'd4;
   localparam logic [2:0] RSEL_VBAS = 3'd5;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
   import pic_pkg::*;
#(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [7:0]       wr_data,
   output logic [LINES-1:0] mask_q,
   output logic [LINES-1:0] trig_q,
   output logic [LINES-1:0] casc_q,
   output logic [7:0]       vbase_q,
   output logic             eoi_pulse,
   output logic             init_pulse
);
   init_st_t st_q;
   logic     need4_q;
   logic     single_q;

   assign init_pulse = wr_en && (wr_addr == ADDR_CMD) && wr_data[CMD_INIT_BIT];
   assign eoi_pulse  = wr_en && (wr_addr == ADDR_CMD) && !wr_data[CMD_INIT_BIT]
                       && wr_data[CMD_EOI_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_RUN;
         need4_q  <= 1'b0;
         single_q <= 1'b0;
         mask_q   <= '0;
         trig_q   <= '0;
         casc_q   <= '0;
         vbase_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CMD: begin
               if (wr_data[CMD_INIT_BIT]) begin
                  st_q     <= ST_VEC;
                  need4_q  <= wr_data[W1_NEED4_BIT];
                  single_q <= wr_data[W1_SINGLE_BIT];
                  mask_q   <= '0;
                  casc_q   <= '0;
               end
            end
            ADDR_DATA: begin
               case (st_q)
                  ST_RUN: mask_q <= wr_data[LINES-1:0];
                  ST_VEC: begin
                     vbase_q <= wr_data;
                     if (!single_q)    st_q <= ST_CASC;
                     else if (need4_q) st_q <= ST_W4;
                     else              st_q <= ST_RUN;
                  end
                  ST_CASC: begin
                     casc_q <= wr_data[LINES-1:0];
                     st_q   <= need4_q ? ST_W4 : ST_RUN;
                  end
                  default: st_q <= ST_RUN;
               endcase
            end
            ADDR_TRIG: trig_q <= wr_data[LINES-1:0];
            default: ;
         endcase
      end
   end

   // R8: the vector word leads to the cascade word unless single mode is set
   p_vec_to_casc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_DATA && st_q == ST_VEC && !single_q) |=> (st_q == ST_CASC));
   // R8: the cascade word returns to run when no fourth word is wanted
   p_casc_to_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_DATA && st_q == ST_CASC && !need4_q) |=> (st_q == ST_RUN));
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req_in,
   input  logic [LINES-1:0] lvl_sense,
   input  logic [LINES-1:0] ack_clr,
   output logic [LINES-1:0] irr
);
   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic bit_q;
      logic prev_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bit_q  <= 1'b0;
            prev_q <= 1'b0;
         end else begin
            prev_q <= req_in[g];
            if (lvl_sense[g])
               bit_q <= req_in[g];
            else if (req_in[g] && !prev_q)
               bit_q <= 1'b1;
            else if (ack_clr[g])
               bit_q <= 1'b0;
         end
      end

      assign irr[g] = bit_q;

      // R2: a level-sensed request tracks the input
      p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_sense[g] |=> (bit_q == $past(req_in[g])));
      // R1: an edge-sensed request holds until acknowledged
      p_edge_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (!lvl_sense[g] && bit_q && !ack_clr[g]) |=> bit_q);
   end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int LINES = 8,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic [LINES-1:0] irr,
   input  logic [LINES-1:0] mask,
   input  logic [LINES-1:0] isr,
   output logic             int_req,
   output logic [IDX_W-1:0] sel_idx,
   output logic [LINES-1:0] sel_oh,
   output logic [LINES-1:0] isr_top_oh
);
   logic [LINES-1:0] pend;
   logic [IDX_W:0]   sel_pos;
   logic [IDX_W:0]   isr_pos;

   always_comb begin
      pend       = irr & ~mask;
      sel_pos    = (IDX_W+1)'(LINES);
      isr_pos    = (IDX_W+1)'(LINES);
      sel_oh     = '0;
      isr_top_oh = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (pend[i]) sel_pos = (IDX_W+1)'(i);
         if (isr[i])  isr_pos = (IDX_W+1)'(i);
      end
      for (int i = 0; i < LINES; i++) begin
         if (sel_pos == (IDX_W+1)'(i)) sel_oh[i]     = 1'b1;
         if (isr_pos == (IDX_W+1)'(i)) isr_top_oh[i] = 1'b1;
      end
      int_req = sel_pos < isr_pos;
      sel_idx = sel_pos[IDX_W-1:0];
   end
endmodule

// File: rtl/pic_core.sv
module pic_core
   import pic_pkg::*;
#(
   parameter int LINES = 8,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   input  logic [2:0]       reg_rsel,
   output logic [7:0]       reg_rdata,
   input  logic [LINES-1:0] irq_in,
   output logic             int_out,
   input  logic             ack_in,
   output logic             ack_valid,
   output logic [IDX_W-1:0] ack_line,
   output logic             ack_cascade
);
   localparam logic [IDX_W-1:0] IDLE_LINE = IDX_W'(LINES - 1);

   if (LINES < 2 || LINES > 8) begin : g_bad_lines
      $error("pic_core: LINES must be between 2 and 8");
   end

   logic [LINES-1:0] mask_q, trig_q, casc_q, irr, isr_q;
   logic [LINES-1:0] sel_oh, isr_top_oh, ack_clr;
   logic [7:0]       vbase_q;
   logic             eoi_pulse, init_pulse, int_req, ack_fire;
   logic [IDX_W-1:0] sel_idx;

   pic_cfg_regs #(.LINES(LINES)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .mask_q(mask_q), .trig_q(trig_q), .casc_q(casc_q), .vbase_q(vbase_q),
      .eoi_pulse(eoi_pulse), .init_pulse(init_pulse)
   );

   pic_req_latch #(.LINES(LINES)) u_req (
      .clk(clk), .rst_n(rst_n), .req_in(irq_in), .lvl_sense(trig_q | casc_q),
      .ack_clr(ack_clr), .irr(irr)
   );

   pic_prio #(.LINES(LINES)) u_prio (
      .irr(irr), .mask(mask_q), .isr(isr_q), .int_req(int_req),
      .sel_idx(sel_idx), .sel_oh(sel_oh), .isr_top_oh(isr_top_oh)
   );

   assign ack_fire    = ack_in && int_req;
   assign ack_clr     = ack_fire ? sel_oh : '0;
   assign int_out     = int_req;
   assign ack_valid   = ack_fire;
   assign ack_line    = int_req ? sel_idx : IDLE_LINE;
   assign ack_cascade = ack_fire && |(sel_oh & casc_q);

   always_ff @(posedge clk) begin
      if (!rst_n)
         isr_q <= '0;
      else if (init_pulse)
         isr_q <= '0;
      else
         isr_q <= (isr_q | ack_clr) & ~(eoi_pulse ? isr_top_oh : '0);
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_rsel)
         RSEL_REQ:  reg_rdata[LINES-1:0] = irr;
         RSEL_ISR:  reg_rdata[LINES-1:0] = isr_q;
         RSEL_MASK: reg_rdata[LINES-1:0] = mask_q;
         RSEL_CASC: reg_rdata[LINES-1:0] = casc_q;
         RSEL_TRIG: reg_rdata[LINES-1:0] = trig_q;
         RSEL_VBAS: reg_rdata            = vbase_q;
         default:   reg_rdata            = '0;
      endcase
   end

   // R4: an accepted acknowledge leaves its line in service
   p_ack_sets_isr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && !init_pulse) |=> |(isr_q & $past(sel_oh)));
   // R10: an acknowledge with nothing deliverable leaves in-service alone
   p_spurious_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in && !int_req && !eoi_pulse && !init_pulse) |=> $stable(isr_q));
   // R6: the output needs an unmasked request
   p_int_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> |(irr & ~mask_q));
   // R7: end-of-interrupt removes exactly one in-service bit
   p_eoi_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_pulse && !ack_fire && |isr_q) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
   // R11: a cascade acknowledge is always an accepted one
   p_casc_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ack_cascade |-> ack_valid);

   for (genvar g = 0; g < LINES; g++) begin : g_casc_chk
      // R3: a cascaded line follows its input level
      p_casc_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
         casc_q[g] |=> (irr[g] == $past(irq_in[g])));
   end
endmodule

// File: tb/pic_core_tb.sv
module pic_core_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       m_wr = 0, s_wr = 0;
   logic [1:0] m_addr = 0, s_addr = 0;
   logic [7:0] m_wdata = 0, s_wdata = 0;
   logic [2:0] m_rsel = 0, s_rsel = 0;
   logic [7:0] m_rdata, s_rdata;
   logic [7:0] b_irq = 0, s_irq = 0;
   logic       m_ack = 0;
   logic       m_int, s_int, m_av, s_av, m_casc, s_casc;
   logic [2:0] m_line, s_line;
   logic [7:0] m_lines;

   assign m_lines = {b_irq[7:3], s_int, b_irq[1:0]};

   pic_core u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(m_wr), .reg_addr(m_addr), .reg_wdata(m_wdata),
      .reg_rsel(m_rsel), .reg_rdata(m_rdata), .irq_in(m_lines), .int_out(m_int),
      .ack_in(m_ack), .ack_valid(m_av), .ack_line(m_line), .ack_cascade(m_casc)
   );

   pic_core u_slv (
      .clk(clk), .rst_n(rst_n), .reg_wr(s_wr), .reg_addr(s_addr), .reg_wdata(s_wdata),
      .reg_rsel(s_rsel), .reg_rdata(s_rdata), .irq_in(s_irq), .int_out(s_int),
      .ack_in(m_casc), .ack_valid(s_av), .ack_line(s_line), .ack_cascade(s_casc)
   );

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // {trigger, mask, inputs, expected int, expected line}
   localparam logic [27:0] VEC [8] = '{
      {8'h00, 8'h00, 8'h10, 1'b1, 3'd4},
      {8'h00, 8'h00, 8'h28, 1'b1, 3'd3},
      {8'h00, 8'h08, 8'h28, 1'b1, 3'd5},
      {8'h00, 8'hFF, 8'h81, 1'b0, 3'd0},
      {8'hFF, 8'h00, 8'h80, 1'b1, 3'd7},
      {8'h00, 8'h01, 8'h03, 1'b1, 3'd1},
      {8'h00, 8'h00, 8'h00, 1'b0, 3'd0},
      {8'h40, 8'h00, 8'hC0, 1'b1, 3'd6}
   };

   task automatic chk(input string rq, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input bit sl, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      if (sl) begin s_wr = 1; s_addr = a; s_wdata = d; end
      else    begin m_wr = 1; m_addr = a; m_wdata = d; end
      @(negedge clk);
      m_wr = 0; s_wr = 0;
   endtask

   task automatic rd(input bit sl, input logic [2:0] s, output logic [7:0] v);
      @(negedge clk);
      if (sl) s_rsel = s; else m_rsel = s;
      #1 v = sl ? s_rdata : m_rdata;
   endtask

   task automatic ack(output logic av, output logic [2:0] ln, output logic cs,
                      output logic sv, output logic [2:0] sln);
      @(negedge clk);
      m_ack = 1;
      #2;
      av = m_av; ln = m_line; cs = m_casc; sv = s_av; sln = s_line;
      @(negedge clk);
      m_ack = 0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 0; b_irq = 0; s_irq = 0; m_ack = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic init_pair;
      wr(0, 2'd0, 8'h10); wr(0, 2'd1, 8'h20); wr(0, 2'd1, 8'h04);
      wr(1, 2'd0, 8'h10); wr(1, 2'd1, 8'h28); wr(1, 2'd1, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all R) actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic av, cs, sv;
      logic [2:0] ln, sln;

      // R9: reset after activity clears everything
      do_reset;
      init_pair;
      b_irq = 8'h11;
      settle(2);
      ack(av, ln, cs, sv, sln);
      do_reset;
      settle(1);
      chk("R9 int after reset", m_int, 0);
      rd(0, 3'd0, v); chk("R9 request", v, 0);
      rd(0, 3'd1, v); chk("R9 in-service", v, 0);
      rd(0, 3'd3, v); chk("R9 cascade", v, 0);
      rd(0, 3'd5, v); chk("R9 vector base", v, 0);
      rd(0, 3'd2, v); chk("R9 mask", v, 0);
      rd(0, 3'd6, v); chk("R12 unused select", v, 0);

      // R8: initialisation orderings
      wr(0, 2'd0, 8'h11); wr(0, 2'd1, 8'h20); wr(0, 2'd1, 8'h04);
      wr(0, 2'd1, 8'h01); wr(0, 2'd1, 8'hAA);
      rd(0, 3'd5, v); chk("R8 vector (cascade+w4)", v, 8'h20);
      rd(0, 3'd3, v); chk("R8 cascade (cascade+w4)", v, 8'h04);
      rd(0, 3'd2, v); chk("R8 mask (cascade+w4)", v, 8'hAA);
      wr(0, 2'd0, 8'h12); wr(0, 2'd1, 8'h40); wr(0, 2'd1, 8'h55);
      rd(0, 3'd5, v); chk("R8 vector (single)", v, 8'h40);
      rd(0, 3'd2, v); chk("R8 mask (single)", v, 8'h55);
      rd(0, 3'd3, v); chk("R8 cascade cleared (single)", v, 0);
      wr(0, 2'd0, 8'h13); wr(0, 2'd1, 8'h60); wr(0, 2'd1, 8'h99); wr(0, 2'd1, 8'h3C);
      rd(0, 3'd2, v); chk("R8 mask (single+w4)", v, 8'h3C);
      wr(0, 2'd2, 8'h5A);
      rd(0, 3'd4, v); chk("R12 trigger register", v, 8'h5A);

      // R5 / R6: priority table
      for (int k = 0; k < 8; k++) begin
         do_reset;
         init_pair;
         wr(0, 2'd2, VEC[k][27:20]);
         wr(0, 2'd1, VEC[k][19:12]);
         @(negedge clk);
         b_irq = VEC[k][11:4];
         settle(2);
         chk($sformatf("R5 R6 vec%0d int", k), m_int, VEC[k][3]);
         if (VEC[k][3]) begin
            ack(av, ln, cs, sv, sln);
            chk($sformatf("R4 vec%0d ack line", k), ln, VEC[k][2:0]);
            chk($sformatf("R4 vec%0d ack valid", k), av, 1);
         end
         b_irq = 0;
      end

      // R1: short edge pulse is held
      do_reset;
      init_pair;
      @(negedge clk); b_irq = 8'h20;
      @(negedge clk); b_irq = 8'h00;
      settle(2);
      chk("R1 edge held int", m_int, 1);
      ack(av, ln, cs, sv, sln);
      chk("R1 edge ack line", ln, 5);
      rd(0, 3'd0, v); chk("R4 edge request cleared", v, 0);
      rd(0, 3'd1, v); chk("R4 edge in-service", v, 8'h20);
      wr(0, 2'd0, 8'h20);
      rd(0, 3'd1, v); chk("R7 eoi clears", v, 0);

      // R2: level request withdrawn
      wr(0, 2'd2, 8'h02);
      @(negedge clk); b_irq = 8'h02;
      settle(2);
      chk("R2 level int", m_int, 1);
      @(negedge clk); b_irq = 8'h00;
      settle(2);
      chk("R2 level withdrawn int", m_int, 0);
      rd(0, 3'd0, v); chk("R2 level request", v, 0);

      // R4: level request survives acknowledge
      @(negedge clk); b_irq = 8'h02;
      settle(2);
      ack(av, ln, cs, sv, sln);
      chk("R4 level ack line", ln, 1);
      rd(0, 3'd0, v); chk("R4 level request kept", v, 8'h02);
      rd(0, 3'd1, v); chk("R4 level in-service", v, 8'h02);
      chk("R5 blocked by own service", m_int, 0);
      wr(0, 2'd0, 8'h20);
      settle(1);
      chk("R7 eoi re-enables level", m_int, 1);
      b_irq = 0;
      wr(0, 2'd2, 8'h00);

      // R5 / R7: nesting
      do_reset;
      init_pair;
      @(negedge clk); b_irq = 8'h48;
      @(negedge clk); b_irq = 8'h00;
      settle(2);
      ack(av, ln, cs, sv, sln);
      chk("R5 first ack line", ln, 3);
      settle(1);
      chk("R5 lower line blocked", m_int, 0);
      @(negedge clk); b_irq = 8'h01;
      @(negedge clk); b_irq = 8'h00;
      settle(2);
      chk("R5 higher line nests", m_int, 1);
      ack(av, ln, cs, sv, sln);
      chk("R5 nested ack line", ln, 0);
      rd(0, 3'd1, v); chk("R5 nested in-service", v, 8'h09);
      wr(0, 2'd0, 8'h20);
      rd(0, 3'd1, v); chk("R7 clears highest only", v, 8'h08);
      chk("R7 line 6 still blocked", m_int, 0);
      wr(0, 2'd0, 8'h20);
      settle(1);
      chk("R7 line 6 released", m_int, 1);
      ack(av, ln, cs, sv, sln);
      chk("R5 line 6 ack", ln, 6);
      wr(0, 2'd0, 8'h20);

      // R10: acknowledge with nothing pending
      settle(1);
      chk("R10 idle int", m_int, 0);
      ack(av, ln, cs, sv, sln);
      chk("R10 spurious valid", av, 0);
      chk("R10 spurious line", ln, 7);
      rd(0, 3'd1, v); chk("R10 in-service unchanged", v, 0);

      // R6: masked request recorded, released on unmask
      wr(0, 2'd1, 8'h10);
      @(negedge clk); b_irq = 8'h10;
      @(negedge clk); b_irq = 8'h00;
      settle(2);
      chk("R6 masked int", m_int, 0);
      rd(0, 3'd0, v); chk("R6 masked request recorded", v, 8'h10);
      wr(0, 2'd1, 8'h00);
      settle(1);
      chk("R6 unmasked int", m_int, 1);

      // R3 / R11: slave line masked while pending
      do_reset;
      init_pair;
      wr(0, 2'd1, 8'hFB);
      @(negedge clk); s_irq = 8'h40;
      settle(3);
      chk("R3 master raised by slave", m_int, 1);
      wr(1, 2'd1, 8'h40);
      settle(2);
      chk("R3 slave int after mask", s_int, 0);
      chk("R3 master withdrawn", m_int, 0);
      settle(6);
      chk("R3 master stays low", m_int, 0);
      ack(av, ln, cs, sv, sln);
      chk("R3 no delivery while masked", av, 0);
      wr(1, 2'd1, 8'h00);
      settle(3);
      chk("R3 master raised on unmask", m_int, 1);
      ack(av, ln, cs, sv, sln);
      chk("R11 master line", ln, 2);
      chk("R11 cascade flag", cs, 1);
      chk("R11 slave valid", sv, 1);
      chk("R11 slave line", sln, 6);
      s_irq = 0;
      settle(3);
      chk("R11 master idle after delivery", m_int, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule